// File: doc/BRIEF.md
# Prescaled Countdown Timer with Auto-Reload

This block is a down-counting interval timer. Software writes a reload value into a load register and then writes a six-bit control word. The control word holds a run enable, a three-bit prescale exponent, an auto-reload select and a start bit. While both start and run enable are set, the timer counts pulses on the `tick_i` input. Every 2^(exp+1) of those pulses it takes one step down.

When the count runs out, the timer has expired. With auto-reload selected, it reloads from the load register and keeps running, which gives a periodic timer. Without auto-reload, the count goes to zero and the start bit clears itself, which gives a one-shot. On every expiry a single-cycle interrupt pulse is raised if the interrupt enable input is high. Both the current count and the control word can be read back at any time.

Top module: `pscl_timer`

## Requirements
- R1: After reset the count, the control read-back and the interrupt output are all zero.
- R2: The control word is laid out as bit 5 = run enable, bits [4:2] = prescale exponent, bit 1 = auto-reload, bit 0 = start. `ctrl_rdata` returns the last value written, except that the start bit may have cleared itself (R7).
- R3: While start and run enable are both 1, the count drops by one on every 2^(exp+1)-th cycle with `tick_i` high. Cycles with `tick_i` low are not counted.
- R4: While start or run enable is 0, the count holds its value.
- R5: A control write that sets start while start is currently 0 loads the count from the load register on that clock edge.
- R6: Every control write, including one that only changes the exponent, restarts the prescale phase from zero. Ticks in the write cycle are not counted.
- R7: Expiry happens on a prescaled step taken while the count is 1 or 0. Without auto-reload, expiry forces the count to 0 and clears the start bit.
- R8: With auto-reload, expiry reloads the count from the load register and start stays 1.
- R9: Each expiry makes `irq_o` high for exactly one cycle, in the cycle after the expiry edge, if `irq_en` was high at that edge. Otherwise no pulse is made.
- R10: If the load value is 0, the timer expires on the first prescaled step after start.
- R11: Writing the load register does not change the current count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer tick enable, one count pulse per high cycle |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6 | Control write data |
| load_we | input | 1 | Load register write strobe |
| load_wdata | input | CNT_W | Load register write data |
| irq_en | input | 1 | Interrupt enable |
| ctrl_rdata | output | 6 | Control register read-back |
| count_o | output | CNT_W | Current count |
| irq_o | output | 1 | Single-cycle expiry interrupt |

## Verification
The checker module tests these rules on every cycle:
- the count holds while stopped;
- each prescaled step lowers the count by exactly one;
- a start-rising write loads the count;
- expiry stops a one-shot and reloads a periodic timer;
- the interrupt is a gated single-cycle pulse.

Other behaviour needs the bench's scenarios, which compare against a behavioural reference model every cycle. These cover the exact 2^(exp+1) step spacing, the prescaler restart when the exponent is rewritten, expiry on a zero load, and a load write that leaves a held count alone.

// File: rtl/pscl_pkg.sv
package pscl_pkg;
  localparam int TMR_EXP_W = 3;
  localparam int TMR_PRE_W = 1 << TMR_EXP_W;

  typedef struct packed {
    logic                 run;
    logic [TMR_EXP_W-1:0] exp;
    logic                 reload;
    logic                 start;
  } tmr_ctrl_t;

  localparam int TMR_CTRL_W = $bits(tmr_ctrl_t);

  // Last prescaler phase before a step: 2^(exp+1) - 1
  function automatic logic [TMR_PRE_W-1:0] presc_top(input logic [TMR_EXP_W-1:0] e);
    logic [TMR_PRE_W:0] t;
    t = {{TMR_PRE_W{1'b0}}, 1'b1} << ({1'b0, e} + 1'b1);
    t = t - 1'b1;
    return t[TMR_PRE_W-1:0];
  endfunction

  // True when a step at this count value is an expiry
  function automatic logic at_end(input logic [31:0] c);
    return c <= 32'd1;
  endfunction
endpackage

// File: rtl/pscl_prescaler.sv
module pscl_prescaler
  import pscl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 active,
  input  logic                 tick,
  input  logic [TMR_EXP_W-1:0] exp_sel,
  output logic                 step
);
  logic [TMR_PRE_W-1:0] phase_q;
  logic                 hit;

  assign hit  = (phase_q == presc_top(exp_sel));
  assign step = active & tick & ~clr & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= '0;
    else if (clr)            phase_q <= '0;
    else if (active && tick) phase_q <= hit ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/pscl_counter.sv
module pscl_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_now,
  input  logic             step,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  import pscl_pkg::*;

  assign expire = step & at_end(32'(count));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (load_now) count <= load_val;
    else if (expire)   count <= reload ? load_val : '0;
    else if (step)     count <= count - 1'b1;
  end
endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
  import pscl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  ctrl_we,
  input  logic [TMR_CTRL_W-1:0] ctrl_wdata,
  input  logic                  load_we,
  input  logic [CNT_W-1:0]      load_wdata,
  input  logic                  irq_en,
  output logic [TMR_CTRL_W-1:0] ctrl_rdata,
  output logic [CNT_W-1:0]      count_o,
  output logic                  irq_o
);
  tmr_ctrl_t        ctrl_q;
  tmr_ctrl_t        ctrl_new;
  logic [CNT_W-1:0] load_q;
  logic             active_w;
  logic             start_rise_w;
  logic             step_w;
  logic             expire_w;

  assign ctrl_new     = tmr_ctrl_t'(ctrl_wdata);
  assign active_w     = ctrl_q.start & ctrl_q.run;
  assign start_rise_w = ctrl_we & ctrl_new.start & ~ctrl_q.start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ctrl_q <= '0;
    else if (ctrl_we)                   ctrl_q <= ctrl_new;
    else if (expire_w && !ctrl_q.reload) ctrl_q.start <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_q <= '0;
    else if (load_we) load_q <= load_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= expire_w & irq_en;
  end

  pscl_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ctrl_we),
    .active  (active_w),
    .tick    (tick_i),
    .exp_sel (ctrl_q.exp),
    .step    (step_w)
  );

  pscl_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_now (start_rise_w),
    .step     (step_w),
    .reload   (ctrl_q.reload),
    .load_val (load_q),
    .count    (count_o),
    .expire   (expire_w)
  );

  assign ctrl_rdata = ctrl_q;
endmodule

// File: rtl/pscl_timer_chk.sv
module pscl_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_we,
  input logic [5:0]       ctrl_wdata,
  input logic             irq_en,
  input logic [5:0]       ctrl_rdata,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o,
  input logic             step_w,
  input logic             expire_w,
  input logic [CNT_W-1:0] load_q
);
  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_we && !(ctrl_rdata[0] && ctrl_rdata[5])) |=> $stable(count_o));

  a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && !expire_w) |=> (count_o == $past(count_o) - 1'b1));

  a_r5_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[0] && !ctrl_rdata[0]) |=> (count_o == $past(load_q)));

  a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && !ctrl_rdata[1]) |=> (count_o == '0 && !ctrl_rdata[0]));

  a_r8_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && ctrl_rdata[1]) |=> (count_o == $past(load_q) && ctrl_rdata[0]));

  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(expire_w) && $past(irq_en)));
endmodule

bind pscl_timer pscl_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_we    (ctrl_we),
  .ctrl_wdata (ctrl_wdata),
  .irq_en     (irq_en),
  .ctrl_rdata (ctrl_rdata),
  .count_o    (count_o),
  .irq_o      (irq_o),
  .step_w     (step_w),
  .expire_w   (expire_w),
  .load_q     (load_q)
);

// File: tb/pscl_timer_tb_top.sv
`timescale 1ns/1ps
module pscl_timer_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_i = 1'b0;
  logic         ctrl_we = 1'b0;
  logic [5:0]   ctrl_wdata = '0;
  logic         load_we = 1'b0;
  logic [W-1:0] load_wdata = '0;
  logic         irq_en = 1'b0;
  logic [5:0]   ctrl_rdata;
  logic [W-1:0] count_o;
  logic         irq_o;

  always #2 clk = ~clk;

  pscl_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .load_we(load_we), .load_wdata(load_wdata),
    .irq_en(irq_en), .ctrl_rdata(ctrl_rdata), .count_o(count_o), .irq_o(irq_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    n_irq = 0;
  string phase = "R1";

  // behavioural reference model
  int m_run, m_exp, m_ar, m_st, m_load, m_cnt, m_pre, m_irq;
  always @(posedge clk) begin
    int ticks_per_step;
    int irq_next;
    if (!rst_n) begin
      m_run = 0; m_exp = 0; m_ar = 0; m_st = 0;
      m_load = 0; m_cnt = 0; m_pre = 0; m_irq = 0;
    end else begin
      irq_next = 0;
      ticks_per_step = 2 ** (m_exp + 1);
      if (ctrl_we) begin
        if (ctrl_wdata[0] && m_st == 0) m_cnt = m_load;
        m_pre = 0;
        m_run = ctrl_wdata[5]; m_exp = ctrl_wdata[4:2];
        m_ar = ctrl_wdata[1]; m_st = ctrl_wdata[0];
      end else if (m_run == 1 && m_st == 1 && tick_i) begin
        m_pre = m_pre + 1;
        if (m_pre == ticks_per_step) begin
          m_pre = 0;
          if (m_cnt < 2) begin
            irq_next = irq_en ? 1 : 0;
            if (m_ar == 1) m_cnt = m_load;
            else begin m_cnt = 0; m_st = 0; end
          end else m_cnt = m_cnt - 1;
        end
      end
      if (load_we) m_load = int'(load_wdata);
      m_irq = irq_next;
    end
  end

  task automatic chk(input string req, input int act, input int exp_v);
    n_cmp++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk({phase, " count"}, int'(count_o), m_cnt);
      chk({phase, " ctrl"}, int'(ctrl_rdata),
          (m_run << 5) | (m_exp << 2) | (m_ar << 1) | m_st);
      chk({phase, " irq"}, int'(irq_o), m_irq);
      if (irq_o) n_irq++;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [5:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_load(input int v);
    load_we = 1'b1; load_wdata = W'(v);
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    int held;
    cyc(3);
    chk("R1 count", int'(count_o), 0);
    chk("R1 ctrl", int'(ctrl_rdata), 0);
    chk("R1 irq", int'(irq_o), 0);
    rst_n = 1'b1;
    cyc(1);

    phase = "R5";
    irq_en = 1'b1;
    wr_load(5);
    tick_i = 1'b1;
    wr_ctrl(6'b100001);
    chk("R5 loaded", int'(count_o), 5);
    phase = "R3";
    cyc(4);
    chk("R3 two steps at exp 0", int'(count_o), 3);

    phase = "R4";
    wr_ctrl(6'b000001);
    cyc(6);
    chk("R4 held while run off", int'(count_o), 3);

    phase = "R7";
    n_irq = 0;
    wr_ctrl(6'b100001);
    cyc(10);
    chk("R7 count zero", int'(count_o), 0);
    chk("R7 start cleared", int'(ctrl_rdata[0]), 0);
    chk("R9 one pulse", n_irq, 1);

    phase = "R8";
    wr_load(2);
    n_irq = 0;
    wr_ctrl(6'b100111);
    cyc(30);
    chk("R8 start kept", int'(ctrl_rdata[0]), 1);
    chk("R9 three pulses", n_irq, 3);
    phase = "R9";
    irq_en = 1'b0;
    n_irq = 0;
    cyc(20);
    chk("R9 masked", n_irq, 0);
    irq_en = 1'b1;

    phase = "R11";
    tick_i = 1'b0;
    cyc(1);
    held = int'(count_o);
    wr_load(9);
    cyc(2);
    chk("R11 count unchanged", int'(count_o), held);

    phase = "R6";
    tick_i = 1'b1;
    cyc(3);
    wr_ctrl(6'b101011);
    for (int i = 0; i < 300; i++) begin
      tick_i = 1'($urandom_range(0, 1));
      if (i == 150) wr_ctrl(6'b100111);
      else cyc(1);
    end
    tick_i = 1'b1;
    wr_ctrl(6'b000000);

    phase = "R10";
    wr_load(0);
    n_irq = 0;
    wr_ctrl(6'b100001);
    cyc(4);
    chk("R10 start cleared", int'(ctrl_rdata[0]), 0);
    chk("R10 count zero", int'(count_o), 0);
    chk("R10 one pulse", n_irq, 1);

    phase = "R2";
    wr_ctrl(6'b011110);
    chk("R2 readback", int'(ctrl_rdata), 6'b011110);
    cyc(2);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule